// File: doc/BRIEF.md
# Audio Transmitter Control/Status Register

This block holds the 16-bit control and status word of an audio transmit section that drives three serial data lines. The word carries one enable bit per transmitter, a group of format control bits, an interrupt-enable bit and two status bits. A processor on a 24-bit data bus writes it and reads it back. The 16-bit word sits in the low part of the bus, and the upper byte always reads as zero.

When every transmitter enable is clear, the block places the transmit section in an individual reset state one clock later. In that state the status bits are cleared and read as zero, and the control bits keep their values. A separate stop input has the same effect on the status bits. A transmitter whose enable is clear has its serial data line forced high. An enabled transmitter passes the bit that comes from the shifting logic.

Format bits should only change while the section sits in individual reset. A write that changes a guarded control bit outside that state raises a one-cycle protocol-error pulse. Status events arrive as single-cycle strobes from the transmit logic.

Top module: `atx_csr`

## Requirements
- R1: `rdata` always presents the register in bits 15:0 and returns zero in bits 23:16. The field positions are: enables in bits 2:0, format in bits 12:3, interrupt enable in bit 13, status in bits 15:14.
- R2: Bit 0 enables transmitter 0, bit 1 enables transmitter 1 and bit 2 enables transmitter 2. A write stores them in the cycle after the write edge, and they appear on `tx_en`.
- R3: A transmitter with its enable clear drives its `sdo` line to 1. An enabled transmitter drives `sdo` with its `sdo_raw` bit.
- R4: When all three enables are clear at a clock edge, `ind_rst` is 1 after that edge, so it follows the last enable clearing by one cycle.
- R5: When any enable is set at a clock edge, `ind_rst` is 0 after that edge.
- R6: While `ind_rst` or `stop_in` is 1, the status bits read as 0, and they stay 0 once that condition ends until a new event occurs.
- R7: Individual reset and stop leave the enable, format and interrupt-enable bits unchanged.
- R8: Both `rst` and `soft_rst` clear every register bit and set `ind_rst` to 1.
- R9: `proto_err` is 1 for one cycle after a write that changes an enable or format bit while `ind_rst` is 0. A write that changes only the interrupt-enable bit, or any write made during individual reset, leaves it 0. The write still takes effect.
- R10: A `tx_evt[i]` strobe sets status bit 14+i, and the bit holds. Writing 1 to status bit 14+i clears it. If a strobe and a clearing write happen in the same cycle, the strobe wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Synchronous software reset with the same effect as `rst` |
| stop_in | input | 1 | Stop state; clears and hides the status bits |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 24 | Write data; bits 15:0 are used |
| rdata | output | 24 | Register read value |
| tx_evt | input | 2 | Status event strobes from the transmit logic |
| sdo_raw | input | 3 | Serial bits from the shifters |
| sdo | output | 3 | Serial data lines after enable gating |
| tx_en | output | 3 | Current transmitter enables |
| fmt | output | 10 | Current format control bits |
| irq_en | output | 1 | Current interrupt enable |
| ind_rst | output | 1 | Transmit section is in individual reset |
| proto_err | output | 1 | Pulse: guarded control bit changed outside individual reset |

## Verification
The bench uses the package defaults: three transmitters, two status bits and ten format bits in a 16-bit word on a 24-bit bus. With only three enables, random writes often produce the all-clear pattern, so the section enters and leaves individual reset many times. With only two status bits, events frequently collide with clearing writes, stop and individual reset. These settings therefore exercise the one-cycle entry and exit of individual reset, status masking, the rule that an event beats a clearing write, and protocol-error detection around those changes.

// File: rtl/atx_csr_pkg.sv
package atx_csr_pkg;
    localparam int TX_N  = 3;
    localparam int ST_N  = 2;
    localparam int REG_W = 16;
    localparam int BUS_W = 24;
    localparam int FMT_W = REG_W - TX_N - 1 - ST_N;
    localparam int PAD_W = BUS_W - REG_W;

    // Register image, most significant field first
    typedef struct packed {
        logic [ST_N-1:0]  stat;
        logic             irq_en;
        logic [FMT_W-1:0] fmt;
        logic [TX_N-1:0]  en;
    } csr_word_t;

    typedef struct packed {
        logic             irq_en;
        logic [FMT_W-1:0] fmt;
        logic [TX_N-1:0]  en;
    } ctrl_t;

    function automatic ctrl_t ctrl_of(logic [REG_W-1:0] w);
        csr_word_t c;
        ctrl_t     r;
        c        = csr_word_t'(w);
        r.irq_en = c.irq_en;
        r.fmt    = c.fmt;
        r.en     = c.en;
        return r;
    endfunction

    function automatic logic [ST_N-1:0] stat_of(logic [REG_W-1:0] w);
        csr_word_t c;
        c = csr_word_t'(w);
        return c.stat;
    endfunction

    // Guarded bits: all control bits except the interrupt enable
    function automatic logic guarded_change(ctrl_t old_c, ctrl_t new_c);
        return (old_c.fmt != new_c.fmt) || (old_c.en != new_c.en);
    endfunction
endpackage

// File: rtl/atx_ctrl_reg.sv
module atx_ctrl_reg
    import atx_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_word,
    input  logic             in_ind_rst,
    output ctrl_t            ctrl,
    output logic             perr
);
    ctrl_t nxt;
    assign nxt = ctrl_of(wr_word);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            ctrl <= '0;
            perr <= 1'b0;
        end else begin
            perr <= wr_en && !in_ind_rst && guarded_change(ctrl, nxt);
            if (wr_en) ctrl <= nxt;
        end
    end
endmodule

// File: rtl/atx_ind_rst.sv
module atx_ind_rst
    import atx_csr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            soft_rst,
    input  logic [TX_N-1:0] en,
    output logic            in_ind_rst
);
    always_ff @(posedge clk) begin
        if (rst || soft_rst) in_ind_rst <= 1'b1;
        else                 in_ind_rst <= ~(|en);
    end
endmodule

// File: rtl/atx_status.sv
module atx_status
    import atx_csr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            soft_rst,
    input  logic            hold_clr,
    input  logic [ST_N-1:0] evt,
    input  logic            wr_en,
    input  logic [ST_N-1:0] clr_mask,
    output logic [ST_N-1:0] stat
);
    for (genvar i = 0; i < ST_N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || soft_rst || hold_clr) stat[i] <= 1'b0;
            else if (evt[i])                 stat[i] <= 1'b1;
            else if (wr_en && clr_mask[i])   stat[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/atx_line_gate.sv
module atx_line_gate
    import atx_csr_pkg::*;
(
    input  logic [TX_N-1:0] en,
    input  logic [TX_N-1:0] raw,
    output logic [TX_N-1:0] line
);
    for (genvar i = 0; i < TX_N; i++) begin : g_line
        assign line[i] = en[i] ? raw[i] : 1'b1;
    end
endmodule

// File: rtl/atx_csr.sv
module atx_csr
    import atx_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             stop_in,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic [ST_N-1:0]  tx_evt,
    input  logic [TX_N-1:0]  sdo_raw,
    output logic [TX_N-1:0]  sdo,
    output logic [TX_N-1:0]  tx_en,
    output logic [FMT_W-1:0] fmt,
    output logic             irq_en,
    output logic             ind_rst,
    output logic             proto_err
);
    ctrl_t           ctrl;
    logic [ST_N-1:0] stat;
    logic            hold;
    csr_word_t       view;

    assign hold = ind_rst | stop_in;

    atx_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en),
        .wr_word(wdata[REG_W-1:0]), .in_ind_rst(ind_rst),
        .ctrl(ctrl), .perr(proto_err)
    );

    atx_ind_rst u_ind (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .en(ctrl.en),
        .in_ind_rst(ind_rst)
    );

    atx_status u_stat (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .hold_clr(hold),
        .evt(tx_evt), .wr_en(wr_en), .clr_mask(stat_of(wdata[REG_W-1:0])),
        .stat(stat)
    );

    atx_line_gate u_gate (
        .en(ctrl.en), .raw(sdo_raw), .line(sdo)
    );

    always_comb begin
        view.en     = ctrl.en;
        view.fmt    = ctrl.fmt;
        view.irq_en = ctrl.irq_en;
        view.stat   = stat & ~{ST_N{hold}};
    end

    assign rdata  = {{PAD_W{1'b0}}, view};
    assign tx_en  = ctrl.en;
    assign fmt    = ctrl.fmt;
    assign irq_en = ctrl.irq_en;
endmodule

// File: rtl/atx_csr_chk.sv
module atx_csr_chk
    import atx_csr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             soft_rst,
    input logic             stop_in,
    input logic             wr_en,
    input logic [BUS_W-1:0] rdata,
    input logic [TX_N-1:0]  sdo,
    input logic [TX_N-1:0]  tx_en,
    input logic             ind_rst,
    input logic             proto_err
);
    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
        rdata[BUS_W-1:REG_W] == '0);

    for (genvar i = 0; i < TX_N; i++) begin : g_line
        assert_idle_high_R3: assert property (@(posedge clk) disable iff (rst)
            !tx_en[i] |-> sdo[i]);
    end

    assert_enter_ind_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_en == '0) |=> ind_rst);

    assert_leave_ind_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_en != '0 && !soft_rst) |=> !ind_rst);

    assert_stat_hidden_R6: assert property (@(posedge clk) disable iff (rst)
        (ind_rst || stop_in) |-> (rdata[REG_W-1:REG_W-ST_N] == '0));

    assert_soft_clear_R8: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (rdata == '0 && ind_rst));

    assert_no_err_in_ind_R9: assert property (@(posedge clk) disable iff (rst)
        (ind_rst && !soft_rst) |=> !proto_err);
endmodule

bind atx_csr atx_csr_chk u_chk (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .stop_in(stop_in),
    .wr_en(wr_en), .rdata(rdata), .sdo(sdo), .tx_en(tx_en),
    .ind_rst(ind_rst), .proto_err(proto_err)
);

// File: tb/atx_csr_test.sv
module atx_csr_test;
    localparam int TXN = 3;
    localparam int STN = 2;
    localparam int NCYC = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        stop_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [23:0] wdata = '0;
    logic [23:0] rdata;
    logic [1:0]  tx_evt = '0;
    logic [2:0]  sdo_raw = '0;
    logic [2:0]  sdo;
    logic [2:0]  tx_en;
    logic [9:0]  fmt;
    logic        irq_en;
    logic        ind_rst;
    logic        proto_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    logic [15:0] m_ctrl;   // bits 13:0 used
    logic [1:0]  m_stat;
    logic        m_ind;
    logic        m_perr;

    always #2.5 clk = ~clk;

    atx_csr uut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .stop_in(stop_in),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .tx_evt(tx_evt),
        .sdo_raw(sdo_raw), .sdo(sdo), .tx_en(tx_en), .fmt(fmt),
        .irq_en(irq_en), .ind_rst(ind_rst), .proto_err(proto_err)
    );

    task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_lines(logic [2:0] en, logic [2:0] raw);
        logic [2:0] r;
        for (int i = 0; i < TXN; i++) r[i] = en[i] ? raw[i] : 1'b1;
        return r;
    endfunction

    function automatic logic [23:0] exp_read(logic [15:0] c, logic [1:0] s, logic hidden);
        return {8'h00, (hidden ? 2'b00 : s), c[13:0]};
    endfunction

    // compare outputs against the model, away from the clock edge
    task automatic compare();
        logic hidden;
        hidden = m_ind | stop_in;
        chk(rdata[23:16] == 8'h00, "R1", rdata, {8'h00, rdata[15:0]});
        chk(rdata == exp_read(m_ctrl, m_stat, hidden), "R1", rdata, exp_read(m_ctrl, m_stat, hidden));
        chk(tx_en == m_ctrl[2:0], "R2", {21'd0, tx_en}, {21'd0, m_ctrl[2:0]});
        chk({irq_en, fmt} == m_ctrl[13:3], "R7", {13'd0, irq_en, fmt}, {13'd0, m_ctrl[13:3]});
        chk(sdo == exp_lines(m_ctrl[2:0], sdo_raw), "R3", {21'd0, sdo}, {21'd0, exp_lines(m_ctrl[2:0], sdo_raw)});
        if (m_ind) chk(ind_rst == 1'b1, "R4", {23'd0, ind_rst}, 24'd1);
        else       chk(ind_rst == 1'b0, "R5", {23'd0, ind_rst}, 24'd0);
        if (hidden) chk(rdata[15:14] == 2'b00, "R6", {22'd0, rdata[15:14]}, 24'd0);
        else        chk(rdata[15:14] == m_stat, "R10", {22'd0, rdata[15:14]}, {22'd0, m_stat});
        chk(proto_err == m_perr, "R9", {23'd0, proto_err}, {23'd0, m_perr});
    endtask

    // advance the model by one clock edge using the inputs now applied
    task automatic model_step();
        logic [15:0] nc;
        logic        hold;
        if (rst || soft_rst) begin
            m_ctrl = '0; m_stat = '0; m_ind = 1'b1; m_perr = 1'b0;
        end else begin
            nc   = {2'b00, wdata[13:0]};
            hold = m_ind | stop_in;
            m_perr = wr_en && !m_ind && (nc[12:0] != m_ctrl[12:0]);
            for (int i = 0; i < STN; i++) begin
                if (hold)                          m_stat[i] = 1'b0;
                else if (tx_evt[i])                m_stat[i] = 1'b1;
                else if (wr_en && wdata[14+i])     m_stat[i] = 1'b0;
            end
            m_ind = (m_ctrl[2:0] == 3'b000);
            if (wr_en) m_ctrl = nc;
        end
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        wr_en = 0; soft_rst = 0; stop_in = 0; tx_evt = '0;
    endtask

    initial begin
        #500000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        m_ctrl = '0; m_stat = '0; m_ind = 1'b1; m_perr = 1'b0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        chk(rdata == 24'd0, "R8", rdata, 24'd0);
        chk(ind_rst == 1'b1, "R8", {23'd0, ind_rst}, 24'd1);
        chk(sdo == 3'b111, "R3", {21'd0, sdo}, 24'd7);
        rst = 0;
        idle();
        cycle();

        // directed: enable tx1 in individual reset, no error (R9), exit (R5)
        wr_en = 1; wdata = 24'h000002; cycle();
        idle(); cycle();
        chk(ind_rst == 1'b0, "R5", {23'd0, ind_rst}, 24'd0);
        // event then clearing write in the same cycle: event wins (R10)
        tx_evt = 2'b01; cycle();
        tx_evt = 2'b01; wr_en = 1; wdata = 24'h004002; cycle();
        idle(); cycle();
        chk(rdata[14] == 1'b1, "R10", rdata, 24'h004002);
        wr_en = 1; wdata = 24'h004002; cycle();
        idle(); cycle();
        chk(rdata[14] == 1'b0, "R10", rdata, 24'h000002);
        // change only interrupt enable while active: no error (R9)
        wr_en = 1; wdata = 24'h002002; cycle();
        idle();
        chk(proto_err == 1'b0, "R9", {23'd0, proto_err}, 24'd0);
        // change format while active: error pulse (R9)
        wr_en = 1; wdata = 24'h002012; cycle();
        idle();
        chk(proto_err == 1'b1, "R9", {23'd0, proto_err}, 24'd1);
        cycle();
        // clear all enables: individual reset one cycle later (R4), control kept (R7)
        tx_evt = 2'b10; cycle();
        idle(); wr_en = 1; wdata = 24'h002010; cycle();
        idle();
        chk(ind_rst == 1'b0, "R4", {23'd0, ind_rst}, 24'd0);
        cycle();
        chk(ind_rst == 1'b1, "R4", {23'd0, ind_rst}, 24'd1);
        chk(rdata == 24'h002010, "R6", rdata, 24'h002010);
        // soft reset clears everything (R8)
        soft_rst = 1; cycle();
        idle();
        chk(rdata == 24'd0 && ind_rst, "R8", rdata, 24'd0);

        // constrained random phase
        for (int n = 0; n < NCYC; n++) begin
            logic [23:0] w;
            soft_rst = ($urandom_range(0, 99) == 0);
            stop_in  = ($urandom_range(0, 9) == 0);
            wr_en    = ($urandom_range(0, 9) < 3);
            w        = $urandom;
            if ($urandom_range(0, 9) < 4) w[2:0] = 3'b000;
            if ($urandom_range(0, 9) < 5) w[12:3] = m_ctrl[12:3];
            wdata    = w;
            tx_evt   = {($urandom_range(0, 4) == 0), ($urandom_range(0, 4) == 0)};
            sdo_raw  = $urandom;
            cycle();
        end

        idle();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule